// File: doc/BRIEF.md
# Instruction Word Slot Sequencer

This block takes 18-bit instruction words one at a time over a valid/ready handshake and hands the opcodes packed inside each word to an execution datapath, one opcode per clock. A word has three 5-bit opcode fields and a 3-bit final field. The final field can only name opcodes whose two low bits are zero. Each issued opcode carries its slot index, a flag for jump-type opcodes together with the target address taken from the bits below that slot, and a duration class (slow for memory-access opcodes, fast for everything else) that the datapath uses for cycle accounting.

A word ends early when a jump-type opcode or a word-ending opcode is issued. The sequencer then raises `word_done` alongside that opcode, skips the remaining slots and becomes ready for the next word. The datapath can hold the current slot with `exec_stall` while it waits on communication. A terminal word (all zeros, or four no-op slots) issues nothing and sets a sticky halt flag that stays set until reset.

Top module: `instruction_slot_sequencer`

## Requirements
- R1: While `rst_n` is low at a rising edge, the block returns to idle: `word_ready`=1, `issue_valid`=0, `word_done`=0 and `halt`=0.
- R2: A word is taken on a rising edge where `word_valid` and `word_ready` are both high. `word_ready` is low from that edge until the edge after its last slot issues, and `issue_valid` is never high together with `word_ready`.
- R3: Slot 0 is bits 17:13, slot 1 is bits 12:8 and slot 2 is bits 7:3. Slots are issued in order starting at slot 0 in the cycle after acceptance, with one slot per cycle, and `issue_slot` gives the index.
- R4: Slot 3 is bits 2:0. A value f in that field is issued as opcode 4*f.
- R5: Opcodes 2, 3, 5, 6 and 7 are jump-type. They raise `issue_jump` and end the word. `issue_addr` is the word's bits below the slot, zero-extended: 13 bits for slot 0, 8 for slot 1 and 3 for slot 2. For any other opcode `issue_addr` is 0.
- R6: Opcodes 0, 1 and 4 end the word at that slot, and later slots are not issued.
- R7: `word_done` is high in exactly the cycle in which the word's last slot is issued without a stall. That last slot is slot 3, or the first jump-type or word-ending slot if one comes earlier. `word_ready` is high on the cycle after it.
- R8: While `exec_stall` is high, the issued slot, its opcode and `issue_valid` stay unchanged at the next edge, and `word_done` is low.
- R9: `issue_slow` is 1 for opcodes 8 to 15 and 0 for all others.
- R10: An accepted word equal to 0, or equal to opcode 28 in slots 0 to 2 with 7 in the final field, issues no slot. `halt` rises on the second edge after acceptance and stays high, with `word_ready` low, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| word_valid | input | 1 | Instruction word offered |
| word_data | input | 18 | Instruction word |
| word_ready | output | 1 | Sequencer can take a word |
| exec_stall | input | 1 | Datapath blocked; hold current slot |
| issue_valid | output | 1 | An opcode is being issued |
| issue_slot | output | 2 | Index of the issued slot |
| issue_op | output | 5 | Issued opcode |
| issue_jump | output | 1 | Issued opcode is jump-type |
| issue_addr | output | 13 | Jump target from the word's lower bits |
| issue_slow | output | 1 | Issued opcode is in the slow duration class |
| word_done | output | 1 | Last slot of the word issued this cycle |
| halt | output | 1 | Terminal word seen; sticky until reset |

## Verification
The assertions assume that `exec_stall`, `word_valid` and `rst_n` are always driven to known levels. They place no limit on how long a stall may last, and they do not require `word_data` to stay stable unless a transfer takes place. The stimulus drives every input at the falling edge and makes each of them 0 or 1, never X or Z. It raises the stall about a quarter of the time and removes all but the two deliberate terminal words from the random stream, so that the run does not halt before the directed halt cases. Each terminal case is preceded by a reset, because the halt state can only be left that way.

// File: rtl/slot_seq_pkg.sv
// Shared constants and types for the instruction slot sequencer.
// Assumes a 5-bit opcode space; the codes below fix the decoder's meaning.
package slot_seq_pkg;

    localparam int OPC_RET       = 0;
    localparam int OPC_EXEC      = 1;
    localparam int OPC_JUMP      = 2;
    localparam int OPC_CALL      = 3;
    localparam int OPC_LOOP_END  = 4;
    localparam int OPC_NEXT      = 5;
    localparam int OPC_IF_ZERO   = 6;
    localparam int OPC_IF_POS    = 7;
    localparam int OPC_SLOW_LO   = 8;
    localparam int OPC_SLOW_HI   = 15;
    localparam int OPC_NOP       = 28;

    // Per-opcode decode flags.
    typedef struct packed {
        logic jump;
        logic ender;
        logic slow;
    } op_class_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_HALT  = 2'd2
    } seq_state_e;

endpackage

// File: rtl/slot_field_extract.sv
// Splits a registered instruction word into its opcode slots and the
// address field that lies below each slot, and flags terminal words.
// Assumes the final slot is narrower than an opcode; it is left-aligned
// so it can only encode opcodes whose low bits are zero.
module slot_field_extract #(
    parameter int WORD_W    = 18,
    parameter int OP_W      = 5,
    parameter int NUM_SLOTS = 4,
    localparam int ADDR_W   = WORD_W - OP_W,
    localparam int LAST_W   = WORD_W - OP_W * (NUM_SLOTS - 1)
) (
    input  logic [WORD_W-1:0]                word_in,
    output logic [NUM_SLOTS-1:0][OP_W-1:0]   slot_op,
    output logic [NUM_SLOTS-1:0][ADDR_W-1:0] slot_addr,
    output logic                             is_terminal
);
    import slot_seq_pkg::*;

    logic [NUM_SLOTS-1:0] nop_hit;

    genvar k;
    generate
        for (k = 0; k < NUM_SLOTS; k++) begin : g_slot
            if (k < NUM_SLOTS - 1) begin : g_full
                localparam int MSB  = WORD_W - 1 - k * OP_W;
                localparam int AW_K = WORD_W - (k + 1) * OP_W;
                // Full-width opcode field and the address bits below it.
                assign slot_op[k]   = word_in[MSB -: OP_W];
                assign slot_addr[k] = ADDR_W'(word_in[AW_K-1:0]);
            end else begin : g_last
                // Short final field, padded with zeros at the bottom.
                assign slot_op[k]   = {word_in[LAST_W-1:0], {(OP_W-LAST_W){1'b0}}};
                assign slot_addr[k] = '0;
            end
            assign nop_hit[k] = (slot_op[k] == OP_W'(OPC_NOP));
        end
    endgenerate

    // A word is terminal if it is empty or holds nothing but no-ops.
    assign is_terminal = (word_in == '0) || (&nop_hit);

endmodule

// File: rtl/op_classifier.sv
// Decodes one opcode into its jump, word-ending and duration-class flags.
// Assumes the code assignment in slot_seq_pkg.
module op_classifier #(
    parameter int OP_W = 5
) (
    input  logic [OP_W-1:0]              op,
    output slot_seq_pkg::op_class_t      cls
);
    import slot_seq_pkg::*;

    // Flag lookup by opcode value.
    always_comb begin
        cls       = '0;
        cls.jump  = (int'(op) == OPC_JUMP)    || (int'(op) == OPC_CALL)  ||
                    (int'(op) == OPC_NEXT)    || (int'(op) == OPC_IF_ZERO) ||
                    (int'(op) == OPC_IF_POS);
        cls.ender = (int'(op) == OPC_RET)     || (int'(op) == OPC_EXEC)  ||
                    (int'(op) == OPC_LOOP_END);
        cls.slow  = (int'(op) >= OPC_SLOW_LO) && (int'(op) <= OPC_SLOW_HI);
    end

endmodule

// File: rtl/slot_seq_fsm.sv
// Control for word acceptance, slot stepping, early word end and halt.
// Assumes the current slot's decode flags are presented combinationally
// for the slot index this module drives.
module slot_seq_fsm #(
    parameter int NUM_SLOTS = 4,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             word_valid,
    input  logic             word_terminal,
    input  logic             exec_stall,
    input  logic             slot_jump,
    input  logic             slot_ender,
    output logic             word_ready,
    output logic             load_word,
    output logic             issue_valid,
    output logic [IDX_W-1:0] slot_idx,
    output logic             word_done,
    output logic             halt
);
    import slot_seq_pkg::*;

    seq_state_e state;
    logic       last_slot;

    assign last_slot   = slot_jump || slot_ender || (slot_idx == IDX_W'(NUM_SLOTS - 1));
    assign word_ready  = (state == ST_IDLE);
    assign load_word   = word_ready && word_valid;
    assign issue_valid = (state == ST_ISSUE) && !word_terminal;
    assign word_done   = issue_valid && !exec_stall && last_slot;
    assign halt        = (state == ST_HALT);

    // State and slot index update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            slot_idx <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (word_valid) begin
                        state    <= ST_ISSUE;
                        slot_idx <= '0;
                    end
                end
                ST_ISSUE: begin
                    if (word_terminal) begin
                        state <= ST_HALT;
                    end else if (!exec_stall) begin
                        if (last_slot) begin
                            state <= ST_IDLE;
                        end else begin
                            slot_idx <= slot_idx + 1'b1;
                        end
                    end
                end
                default: state <= ST_HALT;
            endcase
        end
    end

    p_ready_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
        word_ready |-> !issue_valid);

    p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && exec_stall) |=> (issue_valid && $stable(slot_idx)));

    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && !exec_stall && !word_done) |=>
            (issue_valid && slot_idx == $past(slot_idx) + 1'b1));

    p_done_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        word_done |=> word_ready);

    p_halt_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> (halt && !word_ready));

endmodule

// File: rtl/instruction_slot_sequencer.sv
// Top level: registers an accepted word, steps through its opcode slots
// and presents each one with decode flags and jump address.
// Assumes the datapath samples the issue outputs on every cycle where
// issue_valid is high and exec_stall is low.
module instruction_slot_sequencer #(
    parameter int WORD_W    = 18,
    parameter int OP_W      = 5,
    parameter int NUM_SLOTS = 4,
    localparam int ADDR_W   = WORD_W - OP_W,
    localparam int IDX_W    = $clog2(NUM_SLOTS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              word_ready,
    input  logic              exec_stall,
    output logic              issue_valid,
    output logic [IDX_W-1:0]  issue_slot,
    output logic [OP_W-1:0]   issue_op,
    output logic              issue_jump,
    output logic [ADDR_W-1:0] issue_addr,
    output logic              issue_slow,
    output logic              word_done,
    output logic              halt
);
    import slot_seq_pkg::*;

    logic [WORD_W-1:0]                word_q;
    logic [NUM_SLOTS-1:0][OP_W-1:0]   slot_op;
    logic [NUM_SLOTS-1:0][ADDR_W-1:0] slot_addr;
    logic                             word_terminal;
    logic                             load_word;
    logic [IDX_W-1:0]                 slot_idx;
    op_class_t                        cls;

    // Hold the word being sequenced.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (load_word) begin
            word_q <= word_data;
        end
    end

    slot_field_extract #(
        .WORD_W    (WORD_W),
        .OP_W      (OP_W),
        .NUM_SLOTS (NUM_SLOTS)
    ) u_extract (
        .word_in     (word_q),
        .slot_op     (slot_op),
        .slot_addr   (slot_addr),
        .is_terminal (word_terminal)
    );

    op_classifier #(
        .OP_W (OP_W)
    ) u_classify (
        .op  (slot_op[slot_idx]),
        .cls (cls)
    );

    slot_seq_fsm #(
        .NUM_SLOTS (NUM_SLOTS)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .word_valid    (word_valid),
        .word_terminal (word_terminal),
        .exec_stall    (exec_stall),
        .slot_jump     (cls.jump),
        .slot_ender    (cls.ender),
        .word_ready    (word_ready),
        .load_word     (load_word),
        .issue_valid   (issue_valid),
        .slot_idx      (slot_idx),
        .word_done     (word_done),
        .halt          (halt)
    );

    // Issue outputs for the current slot.
    assign issue_slot = slot_idx;
    assign issue_op   = slot_op[slot_idx];
    assign issue_jump = issue_valid && cls.jump;
    assign issue_slow = issue_valid && cls.slow;
    assign issue_addr = issue_jump ? slot_addr[slot_idx] : '0;

    p_last_field_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && issue_slot == IDX_W'(NUM_SLOTS - 1)) |-> (issue_op[1:0] == 2'b00));

    p_jump_ends_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_jump && !exec_stall) |-> word_done);

    p_stall_no_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        exec_stall |-> !word_done);

    p_op_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_valid && exec_stall) |=> $stable(issue_op));

endmodule

// File: tb/test_instruction_slot_sequencer.sv
// Self-checking bench with a behavioural reference model compared every cycle.
module test_instruction_slot_sequencer;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        word_valid;
    logic [17:0] word_data;
    logic        word_ready;
    logic        exec_stall;
    logic        issue_valid;
    logic [1:0]  issue_slot;
    logic [4:0]  issue_op;
    logic        issue_jump;
    logic [12:0] issue_addr;
    logic        issue_slow;
    logic        word_done;
    logic        halt;

    int n_checks = 0;
    int n_fails  = 0;
    int cyc      = 0;

    always #5 clk = ~clk;

    instruction_slot_sequencer i_instruction_slot_sequencer (
        .clk         (clk),
        .rst_n       (rst_n),
        .word_valid  (word_valid),
        .word_data   (word_data),
        .word_ready  (word_ready),
        .exec_stall  (exec_stall),
        .issue_valid (issue_valid),
        .issue_slot  (issue_slot),
        .issue_op    (issue_op),
        .issue_jump  (issue_jump),
        .issue_addr  (issue_addr),
        .issue_slow  (issue_slow),
        .word_done   (word_done),
        .halt        (halt)
    );

    // ---------------- reference model ----------------
    int          m_state = 0;   // 0 idle, 1 working, 2 halted
    logic [17:0] m_word  = '0;
    int          m_idx   = 0;

    function automatic int op_at(input logic [17:0] w, input int idx);
        case (idx)
            0: return int'(w / (1 << 13)) % 32;
            1: return int'(w / (1 << 8)) % 32;
            2: return int'(w / (1 << 3)) % 32;
            default: return (int'(w) % 8) * 4;
        endcase
    endfunction

    function automatic bit is_jmp(input int op);
        return op == 2 || op == 3 || op == 5 || op == 6 || op == 7;
    endfunction

    function automatic bit is_end(input int op);
        return op == 0 || op == 1 || op == 4;
    endfunction

    function automatic bit is_term(input logic [17:0] w);
        return w == 18'd0 || w == {5'd28, 5'd28, 5'd28, 3'd7};
    endfunction

    function automatic int addr_at(input logic [17:0] w, input int idx);
        if (idx > 2 || !is_jmp(op_at(w, idx))) return 0;
        return int'(w) % (1 << (13 - 5 * idx));
    endfunction

    function automatic bit m_active();
        return m_state == 1 && !is_term(m_word);
    endfunction

    function automatic bit m_last();
        int op;
        op = op_at(m_word, m_idx);
        return is_jmp(op) || is_end(op) || m_idx == 3;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state <= 0;
            m_idx   <= 0;
        end else if (m_state == 0) begin
            if (word_valid) begin
                m_state <= 1;
                m_word  <= word_data;
                m_idx   <= 0;
            end
        end else if (m_state == 1) begin
            if (is_term(m_word)) m_state <= 2;
            else if (!exec_stall) begin
                if (m_last()) m_state <= 0;
                else m_idx <= m_idx + 1;
            end
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0d expected %0d (time %0t)", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int    op;
        bit    act;
        bit    e_done;
        string dtag;
        act = m_active();
        chk("R2", "word_ready", int'(word_ready), int'(m_state == 0));
        chk("R3", "issue_valid", int'(issue_valid), int'(act));
        chk("R10", "halt", int'(halt), int'(m_state == 2));
        e_done = act && !exec_stall && m_last();
        if (act) begin
            op = op_at(m_word, m_idx);
            chk("R3", "issue_slot", int'(issue_slot), m_idx);
            chk(m_idx == 3 ? "R4" : "R3", "issue_op", int'(issue_op), op);
            chk("R5", "issue_jump", int'(issue_jump), int'(is_jmp(op)));
            chk("R5", "issue_addr", int'(issue_addr), addr_at(m_word, m_idx));
            chk("R9", "issue_slow", int'(issue_slow), int'(op >= 8 && op <= 15));
            if (exec_stall) dtag = "R8";
            else if (is_end(op)) dtag = "R6";
            else if (is_jmp(op)) dtag = "R5";
            else dtag = "R7";
        end else begin
            dtag = "R7";
        end
        chk(dtag, "word_done", int'(word_done), int'(e_done));
    endtask

    task automatic cycle(input logic v, input logic [17:0] d, input logic st);
        @(negedge clk);
        word_valid = v;
        word_data  = d;
        exec_stall = st;
        #1;
        compare_all();
    endtask

    function automatic logic [17:0] mkw(input int a, input int b, input int c, input int f);
        return {a[4:0], b[4:0], c[4:0], f[2:0]};
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) cycle(1'b0, 18'd0, 1'b0);
        // R1: idle state after reset
        chk("R1", "reset word_ready", int'(word_ready), 1);
        chk("R1", "reset issue_valid", int'(issue_valid), 0);
        chk("R1", "reset word_done", int'(word_done), 0);
        chk("R1", "reset halt", int'(halt), 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send_word(input logic [17:0] w, input bit stalls);
        bit got = 0;
        for (int g = 0; g < 20 && !got; g++) begin
            got = word_ready;
            cycle(1'b1, w, stalls && ($urandom_range(0, 3) == 0));
        end
        for (int g = 0; g < 60 && (m_state == 1); g++) begin
            cycle(1'b0, 18'h2AAAA, stalls && ($urandom_range(0, 3) == 0));
        end
    endtask

    initial begin
        logic [17:0] dir [10];
        rst_n      = 1'b0;
        word_valid = 1'b0;
        word_data  = '0;
        exec_stall = 1'b0;
        do_reset();

        dir[0] = mkw(28, 20, 24, 6);   // four slots, final maps to 24 (R4)
        dir[1] = mkw(11, 3, 9, 1);     // call in slot 1, 8-bit address (R5)
        dir[2] = mkw(2, 31, 31, 7);    // jump in slot 0, 13-bit address (R5)
        dir[3] = mkw(20, 21, 7, 5);    // -if in slot 2, 3-bit address (R5)
        dir[4] = mkw(0, 28, 0, 1);     // return ends at slot 0 (R6)
        dir[5] = mkw(24, 1, 9, 3);     // exec ends at slot 1 (R6)
        dir[6] = mkw(8, 12, 15, 2);    // slow class throughout (R9)
        dir[7] = mkw(28, 28, 28, 1);   // final unext (R4, R6)
        dir[8] = mkw(28, 28, 28, 5);   // final maps to 20
        dir[9] = mkw(16, 4, 19, 0);    // unext ends at slot 1 (R6)
        foreach (dir[i]) send_word(dir[i], 1'b0);
        foreach (dir[i]) send_word(dir[i], 1'b1);   // R8 stall coverage

        for (int n = 0; n < 800; n++) begin
            logic [17:0] w;
            w = 18'($urandom);
            if (is_term(w)) w = w ^ 18'h00100;
            send_word(w, 1'b1);
            if ($urandom_range(0, 2) == 0) cycle(1'b0, 18'h0, 1'b0);
        end

        // R10: empty word halts and later words are refused
        do_reset();
        send_word(18'd0, 1'b0);
        for (int g = 0; g < 6; g++) cycle(1'b1, mkw(28, 20, 24, 6), 1'b0);
        chk("R10", "halt after empty word", int'(halt), 1);

        // R10: all no-op word halts
        do_reset();
        send_word(mkw(28, 28, 28, 7), 1'b1);
        for (int g = 0; g < 6; g++) cycle(1'b1, mkw(2, 0, 0, 0), 1'b0);
        chk("R10", "halt after no-op word", int'(halt), 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            n_fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule